// File: doc/BRIEF.md
# Buffered-Duty PWM Timer

An up-counting pulse-width generator whose period comes from a programmable limit register and whose duty cycle comes from a compare register. The counter runs from zero up to the limit, then wraps to zero. Each pass through that range is one PWM period. The pin level is derived from the counter and an active compare value.

Software never writes the active compare value directly. A write lands in a pending register and is copied into the active register only on the clock edge at which the counter wraps. The duty cycle therefore changes only at a period boundary, and no shortened or stretched pulse appears. A read of the compare address always returns the pending value, which is the most recent write.

A wrap also feeds a short synchronizer. After the fixed delay, the synchronizer raises a sticky wrap flag. Software clears the flag through a dedicated input.

Top module: `pwm_buffered_timer`

## Requirements
- R1: After reset the counter, the active and pending compare values and the wrap flag are 0, the limit is all ones, the mode is 00, and pwm_out, pwm_oe and wrap_flag are low.
- R2: With cnt_en high, the counter advances by one per clock while it is below the limit. On a clock where it is at or above the limit, it returns to 0. A limit of 0 makes it wrap every clock.
- R3: With cnt_en low, the counter holds its value and no wrap occurs.
- R4: A write to address 1 sets the pending compare value only. The active compare value takes the pending value on the clock edge where the counter wraps, and is unchanged otherwise.
- R5: The read port returns the limit at address 0, the pending compare value at address 1, the mode zero-extended at address 2, and 0 at address 3. Writes use the same addresses.
- R6: In modes 00 and 01, pwm_oe is low and pwm_out is 0.
- R7: In mode 10, the output is set when the counter is 0 and cleared on a compare match. pwm_out is high one clock after each counter value below the active compare value, and low otherwise.
- R8: Mode 11 sets the output on a compare match and clears it at 0, so its level is the inverse of mode 10.
- R9: An active compare value of 0 holds the output low in mode 10 and high in mode 11. An active compare value at or above the limit holds it high in mode 10 and low in mode 11.
- R10: A wrap on a clock edge sets wrap_flag exactly SYNC_DELAY clocks after that edge.
- R11: wrap_flag stays set until a clock with wrap_clr high. When a set and a clear fall on the same clock, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 limit, 1 compare, 2 mode) |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | WIDTH | Read data (combinational) |
| cnt_en | input | 1 | Counter advance enable |
| wrap_clr | input | 1 | Clears the sticky wrap flag |
| pwm_out | output | 1 | PWM pin level, 0 when disconnected |
| pwm_oe | output | 1 | Pin output enable |
| wrap_flag | output | 1 | Sticky wrap flag |

## Verification
The bench keeps the default WIDTH of 8 and SYNC_DELAY of 2, so the synchronizer is the two-stage variant. Programming small limits (0, 3 and 9) at run time makes periods a few clocks long. Many wraps therefore occur within a short run, and in those runs compare writes can collide with a wrap, flag clears can collide with a delayed set, and the limit can drop below the current count. Compare values of 0, equal to the limit and above the limit exercise the forced levels in both active modes.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF          = 2'b00,
    MODE_OFF_ALT      = 2'b01,
    MODE_CLR_ON_MATCH = 2'b10,
    MODE_SET_ON_MATCH = 2'b11
  } pwm_mode_e;

  localparam logic [1:0] ADDR_LIMIT = 2'd0;
  localparam logic [1:0] ADDR_CMP   = 2'd1;
  localparam logic [1:0] ADDR_MODE  = 2'd2;

  function automatic logic mode_drives_pin(pwm_mode_e m);
    return (m == MODE_CLR_ON_MATCH) || (m == MODE_SET_ON_MATCH);
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             latch_cmp,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] cmp_act,
  output pwm_mode_e        mode
);

  localparam int MODE_PAD = WIDTH - 2;

  logic [WIDTH-1:0] cmp_pend;
  logic             wr_limit, wr_cmp, wr_mode;

  assign wr_limit = wr_en && (wr_addr == ADDR_LIMIT);
  assign wr_cmp   = wr_en && (wr_addr == ADDR_CMP);
  assign wr_mode  = wr_en && (wr_addr == ADDR_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit    <= '1;
      cmp_pend <= '0;
      cmp_act  <= '0;
      mode     <= MODE_OFF;
    end else begin
      if (wr_limit) limit <= wr_data;
      if (wr_cmp)   cmp_pend <= wr_data;
      if (wr_mode)  mode <= pwm_mode_e'(wr_data[1:0]);
      if (latch_cmp) cmp_act <= cmp_pend;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_LIMIT: rd_data = limit;
      ADDR_CMP:   rd_data = cmp_pend;
      ADDR_MODE:  rd_data = {{MODE_PAD{1'b0}}, mode};
      default:    rd_data = '0;
    endcase
  end

  AST_ACTIVE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    latch_cmp |=> (cmp_act == $past(cmp_pend))); // R4
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_cmp |=> $stable(cmp_act)); // R4
  AST_PEND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> (cmp_pend == $past(wr_data))); // R4

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] cnt,
  output logic             wrap
);

  function automatic logic [WIDTH-1:0] next_count(
    logic [WIDTH-1:0] c, logic [WIDTH-1:0] lim, logic en);
    if (!en)        return c;
    else if (c >= lim) return '0;
    else            return c + 1'b1;
  endfunction

  assign wrap = cnt_en && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, limit, cnt_en);
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt >= limit) |=> (cnt == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt < limit) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt)); // R3

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] cmp_act,
  input  logic [WIDTH-1:0] limit,
  input  pwm_mode_e        mode,
  output logic             pwm_out,
  output logic             pwm_oe
);

  logic level_q;

  function automatic logic duty_level(
    logic [WIDTH-1:0] c, logic [WIDTH-1:0] cmp,
    logic [WIDTH-1:0] lim, pwm_mode_e m);
    logic hi;
    if (cmp == '0)      hi = 1'b0;
    else if (cmp >= lim) hi = 1'b1;
    else                hi = (c < cmp);
    case (m)
      MODE_CLR_ON_MATCH: return hi;
      MODE_SET_ON_MATCH: return !hi;
      default:           return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= duty_level(cnt, cmp_act, limit, mode);
  end

  assign pwm_oe  = mode_drives_pin(mode);
  assign pwm_out = pwm_oe && level_q;

  AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLR_ON_MATCH && cmp_act == '0) |=> !level_q); // R9
  AST_FIXED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLR_ON_MATCH && cmp_act != '0 && cmp_act >= limit) |=> level_q); // R9
  AST_ZERO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLR_ON_MATCH && cnt == '0 && cmp_act != '0) |=> level_q); // R7
  AST_MATCH_SETS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SET_ON_MATCH && cnt == cmp_act && cmp_act < limit) |=> level_q); // R8

endmodule

// File: rtl/pwm_wrap_flag.sv
module pwm_wrap_flag #(
  parameter int SYNC_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic wrap_clr,
  output logic wrap_flag
);

  logic [SYNC_DELAY-1:0] sync_q;
  logic                  set_now;

  generate
    if (SYNC_DELAY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= wrap_evt;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_DELAY-2:0], wrap_evt};
      end
    end
  endgenerate

  assign set_now = sync_q[SYNC_DELAY-1];

  always_ff @(posedge clk) begin
    if (!rst_n)        wrap_flag <= 1'b0;
    else if (set_now)  wrap_flag <= 1'b1;
    else if (wrap_clr) wrap_flag <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> wrap_flag); // R10
  AST_FLAG_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_flag && !set_now) |=> !wrap_flag); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag && !wrap_clr) |=> wrap_flag); // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_clr && !set_now) |=> !wrap_flag); // R11

endmodule

// File: rtl/pwm_buffered_timer.sv
module pwm_buffered_timer
  import pwm_timer_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             cnt_en,
  input  logic             wrap_clr,
  output logic             pwm_out,
  output logic             pwm_oe,
  output logic             wrap_flag
);

  logic [WIDTH-1:0] limit, cmp_act, cnt;
  logic             wrap;
  pwm_mode_e        mode;

  pwm_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .latch_cmp(wrap),
    .rd_data(rd_data), .limit(limit), .cmp_act(cmp_act), .mode(mode)
  );

  pwm_counter #(.WIDTH(WIDTH)) u_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .limit(limit),
    .cnt(cnt), .wrap(wrap)
  );

  pwm_wave #(.WIDTH(WIDTH)) u_wave (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_act(cmp_act),
    .limit(limit), .mode(mode), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  pwm_wrap_flag #(.SYNC_DELAY(SYNC_DELAY)) u_flag (
    .clk(clk), .rst_n(rst_n), .wrap_evt(wrap), .wrap_clr(wrap_clr),
    .wrap_flag(wrap_flag)
  );

  AST_OFF_MODES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF || mode == MODE_OFF_ALT) |-> (!pwm_oe && !pwm_out)); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (!wrap_flag && !pwm_out && !pwm_oe)); // R1

endmodule

// File: tb/test_pwm_buffered_timer.sv
module test_pwm_buffered_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, cnt_en, wrap_clr;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       pwm_out, pwm_oe, wrap_flag;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string cur_req = "R1";

  typedef struct {
    bit    pin;
    bit    oe;
    bit    flag;
    string req;
  } exp_t;
  exp_t sb[$];

  int m_cnt, m_lim, m_pend, m_act, m_mode;
  bit m_flag, m_s0, m_s1;

  always #4 clk = ~clk;

  pwm_buffered_timer #(.WIDTH(8), .SYNC_DELAY(2)) i_pwm_buffered_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_en(cnt_en), .wrap_clr(wrap_clr), .pwm_out(pwm_out),
    .pwm_oe(pwm_oe), .wrap_flag(wrap_flag)
  );

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one clock of stimulus and pushes the predicted outputs.
  task automatic cyc(bit en, bit clr, bit we, logic [1:0] a, logic [7:0] d);
    bit   hi, lvl, wrp;
    exp_t e;
    cnt_en = en; wrap_clr = clr; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    hi  = (m_act != 0) && ((m_act >= m_lim) || (m_cnt < m_act));
    lvl = (m_mode == 2) ? hi : (m_mode == 3) ? !hi : 1'b0;
    wrp = en && (m_cnt >= m_lim);
    if (m_s1) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    m_s1 = m_s0;
    m_s0 = wrp;
    if (wrp) begin m_act = m_pend; m_cnt = 0; end
    else if (en) m_cnt = m_cnt + 1;
    if (we) begin
      case (a)
        2'd0: m_lim  = d;
        2'd1: m_pend = d;
        2'd2: m_mode = d[1:0];
        default: ;
      endcase
    end
    e.oe   = (m_mode >= 2);
    e.pin  = e.oe && lvl;
    e.flag = m_flag;
    e.req  = cur_req;
    sb.push_back(e);
    @(negedge clk);
    cnt_en = 1'b0; wrap_clr = 1'b0; wr_en = 1'b0;
  endtask

  task automatic run(int n, bit en);
    for (int i = 0; i < n; i++) cyc(en, 1'b0, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, bit en);
    cyc(en, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(logic [1:0] a, int exp, string req);
    rd_addr = a;
    #1;
    chk(req, "rd_data", rd_data, exp);
  endtask

  // Monitor: pops the scoreboard once per clock, away from the edge.
  always @(negedge clk) begin : monitor
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk(e.req, "pwm_oe", pwm_oe, e.oe);
      chk(e.req, "pwm_out", pwm_out, e.pin);
      chk(e.req, "wrap_flag", wrap_flag, e.flag);
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; wr_en = 0; cnt_en = 0; wrap_clr = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 0;
    m_cnt = 0; m_lim = 255; m_pend = 0; m_act = 0; m_mode = 0;
    m_flag = 0; m_s0 = 0; m_s1 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "pwm_out", pwm_out, 0);
    chk("R1", "pwm_oe", pwm_oe, 0);
    chk("R1", "wrap_flag", wrap_flag, 0);
    rd(2'd0, 255, "R1");
    rd(2'd1, 0, "R1");
    rd(2'd2, 0, "R1");

    // R5 read port map, pending value visible before any latch
    cur_req = "R5";
    wr(2'd1, 8'h40, 0);
    rd(2'd1, 8'h40, "R5");
    rd(2'd3, 0, "R5");
    wr(2'd0, 8'd9, 0);
    rd(2'd0, 9, "R5");
    wr(2'd1, 8'd4, 0);
    wr(2'd2, 8'h02, 0);
    rd(2'd2, 2, "R5");

    // R4 first period runs with active 0, new duty after the wrap
    cur_req = "R4";
    run(12, 1);
    // R7 set at zero, clear on match
    cur_req = "R7";
    run(30, 1);
    // R8 inverted mode
    cur_req = "R8";
    wr(2'd2, 8'h03, 1);
    run(30, 1);

    // R9 duty extremes in both modes
    cur_req = "R9";
    wr(2'd1, 8'd0, 1);  run(25, 1);
    wr(2'd2, 8'h02, 1); run(25, 1);
    wr(2'd1, 8'd9, 1);  run(25, 1);
    wr(2'd2, 8'h03, 1); run(25, 1);
    wr(2'd1, 8'd200, 1); run(25, 1);
    wr(2'd2, 8'h02, 1); run(25, 1);

    // R3 disabled counter freezes the waveform
    cur_req = "R3";
    wr(2'd1, 8'd4, 1);
    run(16, 1);
    run(12, 0);
    run(6, 1);

    // R2 limit lowered below count, then limit zero
    cur_req = "R2";
    run(3, 1);
    wr(2'd0, 8'd3, 1);
    run(20, 1);
    cur_req = "R10";
    wr(2'd0, 8'd0, 1);
    run(10, 1);

    // R11 clears colliding with delayed sets
    cur_req = "R11";
    wr(2'd0, 8'd3, 1);
    for (int i = 0; i < 48; i++) cyc(1, (i % 3) == 0, 1'b0, 2'd0, 8'd0);
    run(2, 0);
    cyc(0, 1, 0, 2'd0, 8'd0);
    run(6, 0);

    // R4 compare writes every clock, some on a wrap edge
    cur_req = "R4";
    for (int i = 0; i < 30; i++) cyc(1, 1'b0, 1'b1, 2'd1, 8'((i * 7) % 11));
    rd(2'd1, (29 * 7) % 11, "R5");
    run(10, 1);

    // R6 disconnected modes
    cur_req = "R6";
    wr(2'd2, 8'h00, 1); run(10, 1);
    wr(2'd2, 8'h01, 1); run(10, 1);
    rd(2'd2, 1, "R6");

    run(2, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule